// File: doc/BRIEF.md
# Calendar Alarm Comparator with Per-Field Enables

This block watches a running calendar (second, minute, hour, weekday, day of month, month and year, all in BCD) and raises a level interrupt when the calendar reaches a programmed alarm time. Every alarm field carries its own compare-enable flag. Only the enabled fields take part in the match, so an alarm can ignore the weekday, or fire on any day at a given hour and minute.

Software writes the alarm fields into a staged set. The staged values have no effect until a commit write copies all of them at once into the active compare set, so a half-written alarm is never compared. A status bit records a match even while the interrupt is masked. The interrupt output is that status gated by an enable bit, and the status is cleared by writing a one to it. The calendar counter itself is outside this block. It supplies the field values and a one-cycle pulse each time those values move to a new second.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset every staged field, every active field, the interrupt enable and the status are zero, and `alarm_irq` is low.
- R2: Addresses 0 to 6 hold the staged fields in the order second, minute, hour, weekday, day, month, year. Bit 15 is the field's compare enable. The low bits hold the BCD value, with widths 7, 7, 6, 3, 6, 5 and 8. A read returns exactly these bits, and every other bit reads as zero.
- R3: Staged values have no effect on matching until a write to address 7 with bit 15 set copies all seven staged fields into the active set. A write to address 7 with bit 15 clear does nothing. Address 7 reads as zero.
- R4: A match is evaluated only in a cycle where `cal_tick` is high. A calendar that equals the alarm without a tick sets nothing. Every enabled field must equal its calendar input.
- R5: A field whose active enable is clear (for example the weekday) is left out of the compare, whatever its value.
- R6: With no active field enabled, the status is never set, even if every stored value equals the calendar.
- R7: The status is set only on a tick where the match holds and the match did not hold on the previous tick. A commit forgets the previous tick's result, so the first matching tick after a commit sets the status.
- R8: Bit 0 of address 9 is the status. It stays set until a write to address 9 with bit 0 set, and a write with bit 0 clear leaves it unchanged.
- R9: Bit 0 of address 8 is the interrupt enable. The status latches whether or not it is set, and `alarm_irq` equals status AND enable.
- R10: When a status clear write and a new match fall in the same cycle, the status remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Write address |
| reg_wdata | input | 16 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 16 | Combinational read data |
| cal_tick | input | 1 | One-cycle pulse: calendar inputs hold a new second |
| cal_sec | input | 7 | Calendar second, BCD |
| cal_min | input | 7 | Calendar minute, BCD |
| cal_hour | input | 6 | Calendar hour, BCD |
| cal_wday | input | 3 | Calendar weekday |
| cal_day | input | 6 | Calendar day of month, BCD |
| cal_mon | input | 5 | Calendar month, BCD |
| cal_year | input | 8 | Calendar year, BCD |
| alarm_irq | output | 1 | Alarm interrupt level |

## Verification
The bench checks that staged values stay inert until a commit with the correct flag. A design that compared the staged set would fire before the commit. It checks a matching calendar held over many ticks, where a level-sensitive design would set the status again right after a clear, and it checks that a re-commit re-arms the alarm. It also covers an all-disabled alarm whose zero values equal a zero calendar, which a design with no "at least one enabled" term would flag. Finally, it drives a clear and a match into the same cycle, where a design that lets the clear win would drop the event.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
   localparam int NUM_FIELDS = 7;
   localparam int SEC_W  = 7;
   localparam int MIN_W  = 7;
   localparam int HOUR_W = 6;
   localparam int WDAY_W = 3;
   localparam int DAY_W  = 6;
   localparam int MON_W  = 5;
   localparam int YEAR_W = 8;

   localparam int FIELD_W [NUM_FIELDS] = '{SEC_W, MIN_W, HOUR_W, WDAY_W,
                                           DAY_W, MON_W, YEAR_W};

   // register map: fields occupy 0..NUM_FIELDS-1
   localparam int ADDR_COMMIT = 7;
   localparam int ADDR_IE     = 8;
   localparam int ADDR_STATUS = 9;

   function automatic int field_lsb(int idx);
      int s;
      s = 0;
      for (int k = 0; k < idx; k++) s += FIELD_W[k];
      return s;
   endfunction

   function automatic int cal_bus_w();
      return field_lsb(NUM_FIELDS);
   endfunction

   function automatic int max_field_w();
      int m;
      m = 0;
      for (int k = 0; k < NUM_FIELDS; k++)
         if (FIELD_W[k] > m) m = FIELD_W[k];
      return m;
   endfunction
endpackage

// File: rtl/cal_alarm_slot.sv
module cal_alarm_slot #(
   parameter int FW     = 7,
   parameter int DATA_W = 16,
   parameter int EN_BIT = 15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_hit,
   input  logic [DATA_W-1:0] wdata,
   input  logic              commit,
   input  logic [FW-1:0]     cal_val,
   output logic [DATA_W-1:0] stg_word,
   output logic              care,
   output logic              hit
);
   logic [FW-1:0] stg_val, act_val;
   logic          stg_en, act_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_val <= '0;
         stg_en  <= 1'b0;
      end else if (wr_hit) begin
         stg_val <= wdata[FW-1:0];
         stg_en  <= wdata[EN_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_val <= '0;
         act_en  <= 1'b0;
      end else if (commit) begin
         act_val <= stg_val;
         act_en  <= stg_en;
      end
   end

   always_comb begin
      stg_word            = '0;
      stg_word[FW-1:0]    = stg_val;
      stg_word[EN_BIT]    = stg_en;
   end

   assign care = act_en;
   assign hit  = (act_val == cal_val);

   AST_COMMIT_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (act_val == $past(stg_val)) && (act_en == $past(stg_en))); // R3
   AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(act_val) && $stable(act_en)); // R3
endmodule

// File: rtl/cal_alarm_ctl.sv
module cal_alarm_ctl #(
   parameter int N = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [N-1:0] care,
   input  logic [N-1:0] hit,
   input  logic         commit,
   input  logic         ie_wr,
   input  logic         ie_val,
   input  logic         clr_req,
   output logic         status,
   output logic         ie,
   output logic         irq
);
   logic match_now, prev_match, set_now;

   always_comb begin
      match_now = |care;
      for (int k = 0; k < N; k++)
         if (care[k] && !hit[k]) match_now = 1'b0;
   end

   assign set_now = tick && match_now && !prev_match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      prev_match <= 1'b0;
      else if (commit) prev_match <= 1'b0;
      else if (tick)   prev_match <= match_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       status <= 1'b0;
      else if (set_now) status <= 1'b1;
      else if (clr_req) status <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     ie <= 1'b0;
      else if (ie_wr) ie <= ie_val;
   end

   assign irq = status & ie;

   AST_SET_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status) |-> $past(tick)); // R4
   AST_NONE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (care == '0) && !status |=> !status); // R6
   AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      status && !clr_req |=> status); // R8
   AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
      status && clr_req && !set_now |=> !status); // R8
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set_now |=> status); // R10
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
   import cal_alarm_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int EN_BIT   = 15,
   parameter int ADDR_W   = 4,
   parameter int CTRL_BIT = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cal_tick,
   input  logic [SEC_W-1:0]  cal_sec,
   input  logic [MIN_W-1:0]  cal_min,
   input  logic [HOUR_W-1:0] cal_hour,
   input  logic [WDAY_W-1:0] cal_wday,
   input  logic [DAY_W-1:0]  cal_day,
   input  logic [MON_W-1:0]  cal_mon,
   input  logic [YEAR_W-1:0] cal_year,
   output logic              alarm_irq
);
   localparam int CAL_W = cal_bus_w();

   if (EN_BIT >= DATA_W) begin : g_bad_en
      $error("enable bit outside data word");
   end
   if (max_field_w() > EN_BIT) begin : g_bad_field
      $error("field value overlaps enable bit");
   end
   if (CTRL_BIT >= DATA_W) begin : g_bad_ctrl
      $error("control bit outside data word");
   end
   if ((1 << ADDR_W) <= ADDR_STATUS) begin : g_bad_addr
      $error("address too narrow for register map");
   end

   logic [CAL_W-1:0]  cal_bus;
   logic [DATA_W-1:0] stg_words [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] care, hit;
   logic commit_req, ie_wr, clr_req, status, ie;

   assign cal_bus = {cal_year, cal_mon, cal_day, cal_wday, cal_hour, cal_min, cal_sec};

   assign commit_req = reg_wr && (reg_addr == ADDR_W'(ADDR_COMMIT)) && reg_wdata[EN_BIT];
   assign ie_wr      = reg_wr && (reg_addr == ADDR_W'(ADDR_IE));
   assign clr_req    = reg_wr && (reg_addr == ADDR_W'(ADDR_STATUS)) && reg_wdata[CTRL_BIT];

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_slot
      localparam int W   = FIELD_W[g];
      localparam int LSB = field_lsb(g);
      logic wr_hit;
      assign wr_hit = reg_wr && (reg_addr == ADDR_W'(g));
      cal_alarm_slot #(.FW(W), .DATA_W(DATA_W), .EN_BIT(EN_BIT)) slot_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_hit   (wr_hit),
         .wdata    (reg_wdata),
         .commit   (commit_req),
         .cal_val  (cal_bus[LSB +: W]),
         .stg_word (stg_words[g]),
         .care     (care[g]),
         .hit      (hit[g])
      );
   end

   cal_alarm_ctl #(.N(NUM_FIELDS)) ctl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (cal_tick),
      .care    (care),
      .hit     (hit),
      .commit  (commit_req),
      .ie_wr   (ie_wr),
      .ie_val  (reg_wdata[CTRL_BIT]),
      .clr_req (clr_req),
      .status  (status),
      .ie      (ie),
      .irq     (alarm_irq)
   );

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NUM_FIELDS; k++)
         if (rd_addr == ADDR_W'(k)) rd_data = stg_words[k];
      if (rd_addr == ADDR_W'(ADDR_IE))     rd_data[CTRL_BIT] = ie;
      if (rd_addr == ADDR_W'(ADDR_STATUS)) rd_data[CTRL_BIT] = status;
   end

   AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> (rd_addr != ADDR_W'(ADDR_STATUS)) || rd_data[CTRL_BIT]); // R9
endmodule

// File: tb/cal_alarm_cmp_tb_top.sv
module cal_alarm_cmp_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk; // 4 ns period, 250 MHz

   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [3:0]  rd_addr = 4'd9;
   logic [15:0] rd_data;
   logic        cal_tick = 1'b0;
   logic [6:0]  c_sec = '0, c_min = '0;
   logic [5:0]  c_hour = '0, c_day = '0;
   logic [2:0]  c_wday = '0;
   logic [4:0]  c_mon = '0;
   logic [7:0]  c_year = '0;
   logic        irq;

   cal_alarm_cmp dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .rd_addr(rd_addr), .rd_data(rd_data),
      .cal_tick(cal_tick), .cal_sec(c_sec), .cal_min(c_min), .cal_hour(c_hour),
      .cal_wday(c_wday), .cal_day(c_day), .cal_mon(c_mon), .cal_year(c_year),
      .alarm_irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference model
   int fw [7] = '{7, 7, 6, 3, 6, 5, 8};
   int m_sv [7];
   bit m_se [7];
   int m_av [7];
   bit m_ae [7];
   bit m_st, m_ie, m_prev;

   function automatic int cal_of(int i);
      case (i)
         0: return int'(c_sec);
         1: return int'(c_min);
         2: return int'(c_hour);
         3: return int'(c_wday);
         4: return int'(c_day);
         5: return int'(c_mon);
         default: return int'(c_year);
      endcase
   endfunction

   function automatic int mread(int a);
      if (a < 7) return (m_se[a] ? 32'h8000 : 0) + m_sv[a];
      if (a == 8) return int'(m_ie);
      if (a == 9) return int'(m_st);
      return 0;
   endfunction

   task automatic chk(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   always @(posedge clk) begin
      bit any, ok, match, set, clr, commit, nst;
      if (!rst_n) begin
         for (int i = 0; i < 7; i++) begin
            m_sv[i] = 0; m_se[i] = 0; m_av[i] = 0; m_ae[i] = 0;
         end
         m_st = 0; m_ie = 0; m_prev = 0;
      end else begin
         any = 0; ok = 1;
         for (int i = 0; i < 7; i++)
            if (m_ae[i]) begin
               any = 1;
               if (m_av[i] != cal_of(i)) ok = 0;
            end
         match  = any && ok;
         set    = cal_tick && match && !m_prev;
         clr    = reg_wr && reg_addr == 9 && reg_wdata[0];
         commit = reg_wr && reg_addr == 7 && reg_wdata[15];
         nst    = set || (m_st && !clr);
         if (commit) m_prev = 0;
         else if (cal_tick) m_prev = match;
         if (reg_wr && reg_addr == 8) m_ie = reg_wdata[0];
         if (commit)
            for (int i = 0; i < 7; i++) begin
               m_av[i] = m_sv[i]; m_ae[i] = m_se[i];
            end
         if (reg_wr && reg_addr < 7) begin
            m_sv[reg_addr] = int'(reg_wdata) & ((1 << fw[reg_addr]) - 1);
            m_se[reg_addr] = reg_wdata[15];
         end
         m_st = nst;
      end
      #1;
      if (rst_n && !done) begin
         chk(irq === (m_st && m_ie), "R9 irq vs model", int'(irq), int'(m_st && m_ie));
         chk(rd_data === 16'(mread(int'(rd_addr))),
             (rd_addr == 9) ? "R8 status vs model" : "R2 readback vs model",
             int'(rd_data), mread(int'(rd_addr)));
      end
   end

   task automatic wr(int a, int d);
      @(negedge clk);
      reg_wr = 1; reg_addr = 4'(a); reg_wdata = 16'(d);
      @(negedge clk);
      reg_wr = 0;
   endtask

   task automatic tick();
      @(negedge clk);
      cal_tick = 1;
      @(negedge clk);
      cal_tick = 0;
   endtask

   task automatic setcal(int s, int mi, int h, int w, int d, int mo, int y);
      @(negedge clk);
      c_sec = 7'(s); c_min = 7'(mi); c_hour = 6'(h); c_wday = 3'(w);
      c_day = 6'(d); c_mon = 5'(mo); c_year = 8'(y);
   endtask

   task automatic status_is(int exp, string tag);
      chk(rd_data[0] === exp[0], tag, int'(rd_data[0]), exp);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      repeat (2) @(negedge clk);
      chk(irq === 1'b0, "R1 irq after reset", int'(irq), 0);
      status_is(0, "R1 status after reset");

      // stage alarm: 08:15:30, weekday stored but not enabled
      wr(0, 16'h8030); wr(1, 16'h8015); wr(2, 16'h8008); wr(3, 16'h0005);
      rd_addr = 2; @(negedge clk);
      chk(rd_data === 16'h8008, "R2 hour readback", int'(rd_data), 16'h8008);
      wr(4, 16'hFFFF);
      rd_addr = 4; @(negedge clk);
      chk(rd_data === 16'h803F, "R2 day masked", int'(rd_data), 16'h803F);
      wr(4, 0);
      rd_addr = 7; @(negedge clk);
      chk(rd_data === 16'h0000, "R3 commit reads zero", int'(rd_data), 0);
      rd_addr = 9;

      setcal(8'h30, 8'h15, 8'h08, 2, 1, 1, 8'h24);
      tick();
      status_is(0, "R3 no effect before commit");
      wr(7, 16'h0000);
      tick();
      status_is(0, "R3 commit without flag ignored");

      wr(7, 16'h8000);
      repeat (4) @(negedge clk);
      status_is(0, "R4 no tick no match");
      tick();
      status_is(1, "R5 weekday excluded, match set");
      chk(irq === 1'b0, "R9 latched while masked", int'(irq), 0);
      wr(8, 1);
      chk(irq === 1'b1, "R9 irq after enable", int'(irq), 1);
      wr(9, 0);
      status_is(1, "R8 write zero keeps status");
      wr(9, 1);
      status_is(0, "R8 clear");
      tick(); tick();
      status_is(0, "R7 once per match run");

      setcal(8'h31, 8'h15, 8'h08, 2, 1, 1, 8'h24);
      tick();
      setcal(8'h30, 8'h15, 8'h08, 2, 1, 1, 8'h24);
      tick();
      status_is(1, "R7 refires after mismatch");

      setcal(8'h31, 8'h15, 8'h08, 2, 1, 1, 8'h24);
      tick();
      status_is(1, "R8 sticky over mismatch");
      setcal(8'h30, 8'h15, 8'h08, 2, 1, 1, 8'h24);
      @(negedge clk);
      cal_tick = 1; reg_wr = 1; reg_addr = 9; reg_wdata = 16'h0001;
      @(negedge clk);
      cal_tick = 0; reg_wr = 0;
      status_is(1, "R10 set wins over clear");
      wr(9, 1);

      setcal(8'h31, 8'h15, 8'h09, 2, 1, 1, 8'h24);
      tick();
      setcal(8'h30, 8'h15, 8'h09, 2, 1, 1, 8'h24);
      tick();
      status_is(0, "R4 hour mismatch blocks");

      for (int i = 0; i < 7; i++) wr(i, 0);
      wr(7, 16'h8000);
      setcal(0, 0, 0, 0, 0, 0, 0);
      tick(); tick();
      status_is(0, "R6 no field enabled");

      wr(0, 16'h8000);
      wr(7, 16'h8000);
      tick();
      status_is(1, "R7 seconds-only alarm fires");
      wr(9, 1);
      tick();
      status_is(0, "R7 no refire while held");
      wr(7, 16'h8000);
      tick();
      status_is(1, "R7 recommit rearms");
      wr(8, 0);
      chk(irq === 1'b0, "R9 irq masked again", int'(irq), 0);

      done = 1;
      @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule